// File: doc/BRIEF.md
# Flow-Through Synchronous Static Memory with SECDED Protection

This block is a small single-clock static memory whose read data appears in the cycle that follows the edge that captured the address, with no extra output register. A load command selects the device through three chip-select inputs and starts either a single access or a four-beat burst. Advance commands then step through the four-word group in linear or interleaved order, where the order is fixed at the load. Reads and writes may alternate on consecutive cycles with no idle cycle between them. While a write's data phase is in progress, the data output stays undriven. A low-active clock enable freezes the whole block: no input is sampled and every output keeps its value.

Each word is stored as a 39-bit codeword: 32 data bits, six Hamming check bits and one overall parity bit. Reads correct any single flipped bit and report it. They also report any double flip. On cycles without a user access, a background scrubber reads a word and, in the very next free cycle, writes the corrected word back. It then moves on to the next address, wrapping at the array depth. If the scrubber finds a word it cannot correct, it raises a sticky flag. A fault-injection mask lets the surrounding logic store deliberately damaged codewords.

Top module: `ecc_flow_sram`

## Requirements
- R1: While `en_n` is high, no input is sampled, the array is neither read nor written, and `dout`, `dout_oe`, `ecc_corr`, `ecc_uncorr` and the burst position keep their values. Operation resumes from the same point once `en_n` returns low.
- R2: A load (`adv`=0) accesses the array only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. With any other pattern, no word is written, and `dout_oe` is low in the following cycle.
- R3: After a selected load read (`wr_n`=1) is captured at an edge, `dout` carries the stored word and `dout_oe` is high during the cycle that follows that edge, provided `out_en_n` is low.
- R4: `out_en_n` acts without a clock: while it is high, `dout_oe` is low in the same cycle, and the data phase reappears as soon as it returns low.
- R5: A selected write (`wr_n`=0) stores `din` at the captured address, and `dout_oe` is low in the following cycle. A read of the same address at the very next edge returns the new word.
- R6: After a load at base address B in linear mode (`ilv`=0 at the load), advance beat k (k=1..3) accesses the address B with its two low bits replaced by (B[1:0]+k) mod 4. The access type (read or write) is the one given at the load. A burst write takes a fresh `din` on each beat.
- R7: In interleaved mode (`ilv`=1 at the load), beat k accesses B with its low two bits replaced by B[1:0] XOR k. The value of `ilv` during advance cycles has no effect.
- R8: An advance after the fourth beat, or after a load that did not select the device, makes no access, and `dout_oe` is low in the following cycle.
- R9: On a user write, bit i of `inj_flip` inverts bit i of the 39-bit stored codeword. A later read of a word with exactly one inverted bit returns the original data with `ecc_corr`=1 and `ecc_uncorr`=0.
- R10: A read of a word with two inverted bits gives `ecc_uncorr`=1.
- R11: The scrubber works only in cycles without a user access. It writes back any word it corrects, so after enough idle cycles a re-read of a word that had one injected flip gives `ecc_corr`=0 and the correct data. User results are never disturbed.
- R12: `scrub_fatal` rises once the scrubber reads a word with two inverted bits, and stays high until reset.
- R13: While and just after `rst` is high, `dout_oe`, `ecc_corr`, `ecc_uncorr` and `scrub_fatal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Clock enable, low-active; high stalls the block |
| sel_a_n | input | 1 | Chip select, low-active |
| sel_b | input | 1 | Chip select, high-active |
| sel_c_n | input | 1 | Chip select, low-active |
| wr_n | input | 1 | Low for write, high for read (sampled at load) |
| adv | input | 1 | 0 loads a new address, 1 advances the burst |
| ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, low-active |
| addr | input | ADDR_W | Word address, sampled at load |
| din | input | 32 | Write data |
| inj_flip | input | 39 | Codeword bit inversion mask applied on user writes |
| dout | output | 32 | Corrected read data |
| dout_oe | output | 1 | High while `dout` should drive the shared bus |
| ecc_corr | output | 1 | Current read data needed a single-bit correction |
| ecc_uncorr | output | 1 | Current read word holds an uncorrectable error |
| scrub_fatal | output | 1 | Sticky: scrubber found an uncorrectable word |

## Verification
The hardest situation to reach is the scrubber repairing a damaged word. It has no port of its own and gets array time only in idle cycles, and any user read of the word would hide the repair by correcting the data on the fly. The bench stores a codeword with one inverted bit through `inj_flip`. It reads the word back at the very next edge, before the scrubber can get a free slot, and sees the correction flag. It then leaves the device deselected for more than two full sweeps and reads the word again, expecting clean data with no correction flag. A double inversion is handled the same way, and the bench then watches the sticky flag.

// File: rtl/fsram_pkg.sv
package fsram_pkg;
  localparam int DATA_W = 32;
  localparam int PAR_W  = 6;
  localparam int CODE_W = DATA_W + PAR_W + 1;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              single;
    logic              double;
  } dec_t;

  // Hamming positions 1..CODE_W-1, powers of two hold check bits, bit 0 overall parity
  function automatic logic [CODE_W-1:0] secded_enc(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    logic              s;
    int                k;
    c = '0;
    k = 0;
    for (int i = 1; i < CODE_W; i++) begin
      if ((i & (i - 1)) != 0) begin
        c[i] = d[k];
        k++;
      end
    end
    for (int p = 0; p < PAR_W; p++) begin
      s = 1'b0;
      for (int i = 1; i < CODE_W; i++)
        if (((i >> p) & 1) == 1) s = s ^ c[i];
      c[1 << p] = s;
    end
    c[0] = ^c;
    return c;
  endfunction

  function automatic dec_t secded_dec(input logic [CODE_W-1:0] c);
    dec_t              r;
    logic [PAR_W-1:0]  syn;
    logic              ovr;
    logic [CODE_W-1:0] f;
    int                k;
    syn = '0;
    for (int i = 1; i < CODE_W; i++)
      if (c[i]) syn = syn ^ PAR_W'(i);
    ovr = ^c;
    f = c;
    if (ovr && int'(syn) < CODE_W) f[syn] = ~f[syn];
    r.single = ovr && (int'(syn) < CODE_W);
    r.double = (!ovr && syn != '0) || (ovr && int'(syn) >= CODE_W);
    r.data   = '0;
    k = 0;
    for (int i = 1; i < CODE_W; i++) begin
      if ((i & (i - 1)) != 0) begin
        r.data[k] = f[i];
        k++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/fsram_burst.sv
module fsram_burst #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              sel_ok,
  input  logic              wr_req,
  input  logic              adv,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] addr,
  output logic              acc_valid,
  output logic              acc_wr,
  output logic [ADDR_W-1:0] acc_addr
);
  localparam int GRP_W = 2;

  logic              act, act_wr, mode_ilv;
  logic [ADDR_W-1:0] base;
  logic [GRP_W-1:0]  beat, nb, low;

  always_comb begin
    nb  = beat + GRP_W'(1);
    low = mode_ilv ? (base[GRP_W-1:0] ^ nb) : (base[GRP_W-1:0] + nb);
    if (!adv) begin
      acc_valid = sel_ok;
      acc_wr    = wr_req;
      acc_addr  = addr;
    end else begin
      acc_valid = act && (beat != {GRP_W{1'b1}});
      acc_wr    = act_wr;
      acc_addr  = {base[ADDR_W-1:GRP_W], low};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act      <= 1'b0;
      act_wr   <= 1'b0;
      mode_ilv <= 1'b0;
      base     <= '0;
      beat     <= '0;
    end else if (ce) begin
      if (!adv) begin
        act      <= sel_ok;
        act_wr   <= wr_req;
        base     <= addr;
        beat     <= '0;
        mode_ilv <= ilv;
      end else if (acc_valid) begin
        beat <= nb;
      end else begin
        act <= 1'b0;
      end
    end
  end

  // R1: a stalled cycle leaves the burst position untouched
  assert_stall_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(beat) && $stable(act) && $stable(base)));
endmodule

// File: rtl/fsram_array.sv
module fsram_array #(
  parameter int ADDR_W = 6,
  parameter int CODE_W = 39
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] wdata,
  output logic [CODE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CODE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    if (rd_en) rdata <= mem[addr];
  end

  // R11: user traffic and scrub traffic share one port, never both in one cycle
  assert_port_excl_R11: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !wr_en);
endmodule

// File: rtl/fsram_scrub.sv
module fsram_scrub #(
  parameter int ADDR_W = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ce,
  input  logic                         idle,
  input  fsram_pkg::dec_t              dec,
  output logic                         s_rd,
  output logic                         s_wr,
  output logic [ADDR_W-1:0]            s_addr,
  output logic [fsram_pkg::CODE_W-1:0] s_wdata,
  output logic                         fatal
);
  localparam int DEPTH = 1 << ADDR_W;

  logic phase;

  assign s_rd    = ce && idle && !phase;
  assign s_wr    = ce && idle && phase && dec.single;
  assign s_wdata = fsram_pkg::secded_enc(dec.data);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= 1'b0;
      s_addr <= '0;
      fatal  <= 1'b0;
    end else if (ce) begin
      if (idle) begin
        if (!phase) begin
          phase <= 1'b1;
        end else begin
          phase  <= 1'b0;
          s_addr <= (int'(s_addr) == DEPTH - 1) ? '0 : s_addr + ADDR_W'(1);
          if (dec.double) fatal <= 1'b1;
        end
      end else begin
        phase <= 1'b0;
      end
    end
  end

  // R12: once raised the flag stays
  assert_fatal_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    fatal |=> fatal);
  // R11: a user access between read and write-back forces a retry of the same word
  assert_scrub_retry_R11: assert property (@(posedge clk) disable iff (rst)
    (phase && ce && !idle) |=> ($stable(s_addr) && !phase));
endmodule

// File: rtl/ecc_flow_sram.sv
module ecc_flow_sram #(
  parameter int ADDR_W = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en_n,
  input  logic                         sel_a_n,
  input  logic                         sel_b,
  input  logic                         sel_c_n,
  input  logic                         wr_n,
  input  logic                         adv,
  input  logic                         ilv,
  input  logic                         out_en_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [fsram_pkg::DATA_W-1:0] din,
  input  logic [fsram_pkg::CODE_W-1:0] inj_flip,
  output logic [fsram_pkg::DATA_W-1:0] dout,
  output logic                         dout_oe,
  output logic                         ecc_corr,
  output logic                         ecc_uncorr,
  output logic                         scrub_fatal
);
  import fsram_pkg::*;

  logic              ce, sel_ok;
  logic              acc_valid, acc_wr;
  logic [ADDR_W-1:0] acc_addr, s_addr, port_addr;
  logic              s_rd, s_wr, rd_en, wr_en, ph_rd;
  logic [CODE_W-1:0] s_wdata, wdata, rdata;
  dec_t              dec;

  assign ce     = !en_n;
  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

  fsram_burst #(.ADDR_W(ADDR_W)) burst_i (
    .clk(clk), .rst(rst), .ce(ce), .sel_ok(sel_ok), .wr_req(!wr_n),
    .adv(adv), .ilv(ilv), .addr(addr),
    .acc_valid(acc_valid), .acc_wr(acc_wr), .acc_addr(acc_addr)
  );

  assign port_addr = acc_valid ? acc_addr : s_addr;
  assign rd_en     = (ce && acc_valid && !acc_wr) || s_rd;
  assign wr_en     = (ce && acc_valid && acc_wr) || s_wr;
  assign wdata     = acc_valid ? (secded_enc(din) ^ inj_flip) : s_wdata;

  fsram_array #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) array_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
    .addr(port_addr), .wdata(wdata), .rdata(rdata)
  );

  assign dec = secded_dec(rdata);

  fsram_scrub #(.ADDR_W(ADDR_W)) scrub_i (
    .clk(clk), .rst(rst), .ce(ce), .idle(!acc_valid), .dec(dec),
    .s_rd(s_rd), .s_wr(s_wr), .s_addr(s_addr), .s_wdata(s_wdata),
    .fatal(scrub_fatal)
  );

  always_ff @(posedge clk) begin
    if (rst)     ph_rd <= 1'b0;
    else if (ce) ph_rd <= acc_valid && !acc_wr;
  end

  assign dout       = dec.data;
  assign dout_oe    = ph_rd && !out_en_n;
  assign ecc_corr   = ph_rd && dec.single;
  assign ecc_uncorr = ph_rd && dec.double;

  // R5: the data phase of a write never drives the bus
  assert_write_no_drive_R5: assert property (@(posedge clk) disable iff (rst)
    (ce && acc_valid && acc_wr) |=> !dout_oe);
  // R2: a cycle without access leaves the bus undriven
  assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (ce && !acc_valid) |=> (!dout_oe && !ecc_corr && !ecc_uncorr));
endmodule

// File: tb/ecc_flow_sram_tb.sv
module ecc_flow_sram_tb_top;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  typedef struct {
    bit          chk;
    bit          oe;
    bit          chk_data;
    logic [31:0] data;
    bit          corr;
    bit          uncorr;
    int          req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en_n = 1'b0, sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic          wr_n = 1'b1, adv = 1'b0, ilv = 1'b0, out_en_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   din = '0;
  logic [38:0]   inj_flip = '0;
  logic [31:0]   dout;
  logic          dout_oe, ecc_corr, ecc_uncorr, scrub_fatal;

  int   n_tests = 0, n_fail = 0;
  exp_t q[$];
  exp_t last;
  logic [31:0] mdl [NW];
  int          flips [NW];

  always #5 clk = ~clk;

  ecc_flow_sram #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .en_n(en_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .wr_n(wr_n), .adv(adv), .ilv(ilv), .out_en_n(out_en_n),
    .addr(addr), .din(din), .inj_flip(inj_flip), .dout(dout), .dout_oe(dout_oe),
    .ecc_corr(ecc_corr), .ecc_uncorr(ecc_uncorr), .scrub_fatal(scrub_fatal)
  );

  task automatic check(input bit ok, input int req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", req, act, expv);
    end
  endtask

  // monitor: compares one expected item per clock edge, mid-cycle
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (e.chk) begin
          check(dout_oe == e.oe, e.req, {31'd0, dout_oe}, {31'd0, e.oe});
          if (e.oe && e.chk_data) check(dout == e.data, e.req, dout, e.data);
          check(ecc_corr == e.corr, e.req, {31'd0, ecc_corr}, {31'd0, e.corr});
          check(ecc_uncorr == e.uncorr, e.req, {31'd0, ecc_uncorr}, {31'd0, e.uncorr});
        end
      end
    end
  end

  function automatic exp_t rd_exp(input int a, input int req);
    exp_t e;
    e.chk = 1; e.oe = 1; e.req = req;
    e.chk_data = (flips[a] < 2);
    e.data = mdl[a];
    e.corr = (flips[a] == 1);
    e.uncorr = (flips[a] == 2);
    return e;
  endfunction

  function automatic exp_t quiet_exp(input int req);
    exp_t e;
    e.chk = 1; e.oe = 0; e.chk_data = 0; e.data = '0; e.corr = 0; e.uncorr = 0; e.req = req;
    return e;
  endfunction

  task automatic push(input exp_t e);
    q.push_back(e);
    last = e;
  endtask

  task automatic sel_good();
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
  endtask

  task automatic t_idle(input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      @(negedge clk);
      en_n = 0; adv = 0; sel_a_n = 1; sel_b = 0; sel_c_n = 1; wr_n = 1; inj_flip = '0;
      e = quiet_exp(0);
      e.chk = 0;
      push(e);
    end
  endtask

  task automatic t_read(input int a, input int req);
    @(negedge clk);
    en_n = 0; adv = 0; sel_good(); wr_n = 1; addr = AW'(a); inj_flip = '0;
    push(rd_exp(a, req));
  endtask

  task automatic t_write(input int a, input logic [31:0] d, input logic [38:0] inj, input int nflip, input int req);
    @(negedge clk);
    en_n = 0; adv = 0; sel_good(); wr_n = 0; addr = AW'(a); din = d; inj_flip = inj;
    mdl[a] = d;
    flips[a] = nflip;
    push(quiet_exp(req));
  endtask

  task automatic t_stall(input int req);
    exp_t e;
    @(negedge clk);
    en_n = 1; adv = 0; sel_good(); wr_n = ~wr_n; addr = addr + AW'(5); din = ~din;
    e = last;
    e.req = req;
    push(e);
  endtask

  function automatic int beat_addr(input int b, input bit il, input int k);
    int lo;
    lo = il ? ((b & 3) ^ k) : (((b & 3) + k) & 3);
    return (b & ~3) | lo;
  endfunction

  task automatic t_burst(input int b, input bit il, input bit wr, input int beats, input int stall_at, input int req);
    for (int k = 0; k < beats; k++) begin
      int a;
      if (k == stall_at) t_stall(1);
      a = beat_addr(b, il, k);
      @(negedge clk);
      en_n = 0; sel_good(); inj_flip = '0;
      if (k == 0) begin
        adv = 0; addr = AW'(b); wr_n = !wr; ilv = il;
      end else begin
        adv = 1; addr = ~addr; wr_n = wr; ilv = !il;
      end
      din = 32'hB000_0000 + 32'(a) + 32'(k << 8);
      if (k >= 4) push(quiet_exp(8));
      else if (wr) begin
        mdl[a] = din;
        flips[a] = 0;
        push(quiet_exp(req));
      end else push(rd_exp(a, req));
    end
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin mdl[i] = '0; flips[i] = 0; end
    last = quiet_exp(0);
    repeat (3) @(negedge clk);
    #1;
    // R13: reset state
    check(dout_oe == 0, 13, {31'd0, dout_oe}, 0);
    check(scrub_fatal == 0, 13, {31'd0, scrub_fatal}, 0);
    @(negedge clk);
    rst = 0;

    // R5 / R3: write then immediate read, alternating traffic
    t_write(3, 32'hA5A5_0003, '0, 0, 5);
    t_read(3, 5);
    t_write(10, 32'h1234_5678, '0, 0, 5);
    t_read(10, 3);
    t_read(3, 3);
    t_write(11, 32'hCAFE_0011, '0, 0, 5);
    t_read(11, 5);
    t_write(3, 32'h0BAD_F00D, '0, 0, 5);
    t_read(3, 5);

    // R2: every non-selecting pattern gives no access
    for (int p = 0; p < 8; p++) begin
      if (p != 2) begin
        @(negedge clk);
        en_n = 0; adv = 0; wr_n = 1; addr = 6'd3;
        {sel_a_n, sel_b, sel_c_n} = 3'(p);
        push(quiet_exp(2));
      end
    end
    // R2: deselected write ignored, read afterwards shows old word
    @(negedge clk);
    en_n = 0; adv = 0; wr_n = 0; addr = 6'd3; din = 32'hDEAD_DEAD;
    sel_a_n = 1; sel_b = 1; sel_c_n = 0;
    push(quiet_exp(2));
    t_read(3, 2);

    // R4: asynchronous output enable during a read data phase
    t_read(10, 3);
    @(posedge clk);
    #3;
    out_en_n = 1;
    #1;
    check(dout_oe == 0, 4, {31'd0, dout_oe}, 0);
    out_en_n = 0;
    #1;
    check(dout_oe == 1, 4, {31'd0, dout_oe}, 1);

    // R1: stall after a read keeps its output, then the next read proceeds
    t_read(10, 3);
    t_stall(1);
    t_stall(1);
    t_read(3, 1);

    // R6 linear burst write, R7 interleaved burst read with a stall inside
    t_burst(22, 0, 1, 4, -1, 6);
    t_burst(21, 1, 0, 4, 2, 7);
    t_burst(23, 0, 0, 4, 1, 6);
    // R8: advances past the fourth beat
    t_burst(17, 1, 1, 4, -1, 7);
    t_burst(18, 1, 0, 6, -1, 7);
    // R8: advance after a deselected load
    @(negedge clk);
    en_n = 0; adv = 0; sel_a_n = 1; sel_b = 0; sel_c_n = 1; wr_n = 1;
    push(quiet_exp(8));
    @(negedge clk);
    adv = 1;
    push(quiet_exp(8));
    t_read(17, 7);

    // R9: one flipped bit corrected on read
    t_write(40, 32'h600D_0040, 39'(1) << 5, 1, 9);
    t_read(40, 9);
    // R11: scrubber repairs it during idle cycles
    t_idle(300);
    flips[40] = 0;
    t_read(40, 11);
    t_read(3, 11);
    @(negedge clk);
    check(scrub_fatal == 0, 12, {31'd0, scrub_fatal}, 0);

    // R10: two flipped bits detected on read
    t_write(41, 32'h0000_0041, (39'(1) << 2) | (39'(1) << 20), 2, 10);
    t_read(41, 10);
    // R12: scrubber meets the bad word and latches the flag
    t_idle(300);
    @(negedge clk);
    check(scrub_fatal == 1, 12, {31'd0, scrub_fatal}, 1);
    t_read(40, 11);
    t_idle(20);
    @(negedge clk);
    check(scrub_fatal == 1, 12, {31'd0, scrub_fatal}, 1);

    // R13: reset clears the flag
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    check(scrub_fatal == 0, 13, {31'd0, scrub_fatal}, 0);
    check(dout_oe == 0, 13, {31'd0, dout_oe}, 0);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule